// File: doc/BRIEF.md
# Synchronous Serial Master Transmitter

This block sends characters over a two-wire, half-duplex synchronous link. It drives a data line and a companion clock line, and it is the master on the link. Characters come in through a valid/ready write port and land in a one-entry holding register. When the shift register is free, the character moves into it and is shifted out least significant bit first. The block makes exactly one clock pulse for each data bit. It sends no start or stop framing, and the clock stays at its idle level whenever no bit is on the line.

A 16-bit divisor sets how long each half of the bit clock lasts, counted in system clock cycles. A polarity input picks the idle level of the clock. The leading edge of a bit is the edge that leaves the idle level, and data changes only on that edge, so each bit is steady at the trailing edge. In 9-bit mode a ninth bit, taken from a configuration input at the moment the character is accepted, goes out after the eight data bits.

Back-pressure works like this: `in_ready` is high only when the port is active and the holding register is empty. A character is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_data` and `bit9` must be steady while `in_valid` is high. A source may hold `in_valid` high for any number of cycles until the character is taken. The port is active when it is enabled, set as master, set to transmit, and not set to receive. When the port stops being active, any character in progress is dropped.

Top module: `sst_master_tx`

## Requirements
- R1: When a character is taken and the shift register is idle, `hold_empty` falls on the following edge. On the next edge the character moves to the shift register: `hold_empty` rises again, `idle` falls, and the clock leaves its idle level.
- R2: A character taken while the shift register is busy waits in the holding register. It is loaded on the edge that ends the trailing half of the last bit of the previous character, with no idle clock cycle between the two characters. `in_ready` stays low while the holding register is full.
- R3: Bits go out least significant bit first with no start or stop bits. `dat_o` is 0 whenever `idle` is high.
- R4: Each character makes exactly 8 clock pulses, or 9 in 9-bit mode. No pulse appears while `idle` is high.
- R5: With `clk_pol` = 1 the clock idles high and its leading edge is falling. With `clk_pol` = 0 it idles low and its leading edge is rising.
- R6: While a character is in progress, `dat_o` changes only in the cycle where `sck_o` leaves its idle level. So each bit is steady across its trailing edge.
- R7: With `nine_bit` = 1 when a character is taken, the value of `bit9` at that edge is sent as the ninth and last bit.
- R8: Each half of a bit (clock active, then clock idle) lasts `divisor` + 1 system clock cycles.
- R9: `dat_oe` and `sck_oe` are 1 exactly when `port_en` = 1, `master` = 1, `tx_en` = 1 and `rx_en` = 0.
- R10: While the port is not active, the character in progress and the waiting character are dropped. From the next edge on, `idle` = 1, `hold_empty` = 1 and the clock is at its idle level. `in_ready` is 0 while the port is not active.
- R11: After reset, `idle` = 1, `hold_empty` = 1, `dat_o` = 0, and `sck_o` equals `clk_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| master | input | 1 | Master mode select |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive selected (turns transmit off) |
| clk_pol | input | 1 | Clock idle level (1 = idle high) |
| nine_bit | input | 1 | 9-bit character mode |
| bit9 | input | 1 | Ninth bit, sampled when a character is taken |
| divisor | input | 16 | Half-bit length minus one, in system clocks |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Holding register can take a character |
| in_data | input | 8 | Character data |
| dat_o | output | 1 | Serial data line |
| dat_oe | output | 1 | Data line driver enable |
| sck_o | output | 1 | Serial clock line |
| sck_oe | output | 1 | Clock line driver enable |
| hold_empty | output | 1 | Holding register is empty |
| idle | output | 1 | Shift register has finished its last bit |

## Verification
On every cycle the assertions check four things. The clock sits at its idle level whenever the shifter is idle. Data changes only together with a leading clock edge. A taken character fills the holding register, and it moves on at once when the shifter is free. Deactivation clears both registers. Only the bench scenarios show the rest. They collect the bits at trailing edges and count leading edges, which confirms LSB-first order, the 8 and 9 bit counts with the sampled ninth bit, and the back-to-back hand-off with no gap. A cycle-level reference model also tracks the half-bit length for several divisor values and both polarities.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int DATA_W  = 8;
  localparam int CHAR_W  = DATA_W + 1;
  localparam int IDX_W   = $clog2(CHAR_W);

  typedef struct packed {
    logic              nine;
    logic [CHAR_W-1:0] bits;
  } sst_char_t;
endpackage

// File: rtl/sst_holdreg.sv
module sst_holdreg
  import sst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bit9,
  input  logic              nine_bit,
  input  logic              take,
  output logic              full,
  output sst_char_t         held
);
  logic accept;

  assign in_ready = active & ~full;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (!active) begin
      full <= 1'b0;
    end else if (accept) begin
      full       <= 1'b1;
      held.nine  <= nine_bit;
      held.bits  <= {bit9, in_data};
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sst_bitclk.sv
module sst_bitclk #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run & (cnt == divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  logic      tick,
  input  logic      pend,
  input  sst_char_t held,
  output logic      take,
  output logic      busy,
  output logic      phase,
  output logic      dout
);
  logic [CHAR_W-1:0] sh;
  logic [IDX_W-1:0]  idx;
  logic              nine_q;
  logic              last_bit;
  logic              end_char;

  assign last_bit = idx == (nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1));
  assign end_char = busy & tick & phase & last_bit;
  assign take     = active & pend & (~busy | end_char);
  assign dout     = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase <= 1'b0; idx <= '0; sh <= '0; nine_q <= 1'b0;
    end else if (!active) begin
      busy <= 1'b0; phase <= 1'b0; idx <= '0; sh <= '0; nine_q <= 1'b0;
    end else if (take) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      idx    <= '0;
      sh     <= held.bits;
      nine_q <= held.nine;
    end else if (busy && tick) begin
      if (!phase) begin
        phase <= 1'b1;
      end else if (last_bit) begin
        busy  <= 1'b0;
        phase <= 1'b0;
        sh    <= '0;
      end else begin
        phase <= 1'b0;
        idx   <= idx + 1'b1;
        sh    <= sh >> 1;
      end
    end
  end
endmodule

// File: rtl/sst_master_tx.sv
module sst_master_tx
  import sst_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              master,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              clk_pol,
  input  logic              nine_bit,
  input  logic              bit9,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              dat_o,
  output logic              dat_oe,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              hold_empty,
  output logic              idle
);
  logic      active;
  logic      full;
  logic      take;
  logic      busy;
  logic      phase;
  logic      dout;
  logic      tick;
  sst_char_t held;

  assign active = port_en & master & tx_en & ~rx_en;

  sst_holdreg u_hold (
    .clk(clk), .rst_n(rst_n), .active(active),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .bit9(bit9), .nine_bit(nine_bit), .take(take),
    .full(full), .held(held)
  );

  sst_bitclk #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run(busy), .divisor(divisor), .tick(tick)
  );

  sst_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
    .pend(full), .held(held), .take(take),
    .busy(busy), .phase(phase), .dout(dout)
  );

  assign dat_o      = busy & dout;
  assign sck_o      = (busy & ~phase) ? ~clk_pol : clk_pol;
  assign dat_oe     = active;
  assign sck_oe     = active;
  assign hold_empty = ~full;
  assign idle       = ~busy;
endmodule

// File: rtl/sst_master_tx_chk.sv
module sst_master_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic master,
  input logic tx_en,
  input logic rx_en,
  input logic clk_pol,
  input logic in_valid,
  input logic in_ready,
  input logic dat_o,
  input logic sck_o,
  input logic hold_empty,
  input logic idle
);
  logic act;
  assign act = port_en & master & tx_en & ~rx_en;

  assert_idle_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (sck_o == clk_pol));

  assert_fill_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !hold_empty);

  assert_prompt_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !hold_empty && idle) |=> (!idle && hold_empty));

  assert_data_on_leading_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle) && (dat_o != $past(dat_o))) |-> (sck_o != clk_pol));

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (idle && hold_empty));

  assert_hold_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !hold_empty && !idle) |-> !in_ready);
endmodule

bind sst_master_tx sst_master_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .master(master),
  .tx_en(tx_en), .rx_en(rx_en), .clk_pol(clk_pol), .in_valid(in_valid),
  .in_ready(in_ready), .dat_o(dat_o), .sck_o(sck_o),
  .hold_empty(hold_empty), .idle(idle)
);

// File: tb/tb_sst_master_tx.sv
module tb_sst_master_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 1, master = 1, tx_en = 1, rx_en = 0, clk_pol = 0;
  logic nine_bit = 0, bit9 = 0, in_valid = 0;
  logic [15:0] divisor = 16'd2;
  logic [7:0] in_data = '0;
  logic in_ready, dat_o, dat_oe, sck_o, sck_oe, hold_empty, idle;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sst_master_tx dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .master(master),
    .tx_en(tx_en), .rx_en(rx_en), .clk_pol(clk_pol), .nine_bit(nine_bit),
    .bit9(bit9), .divisor(divisor), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .dat_o(dat_o), .dat_oe(dat_oe), .sck_o(sck_o),
    .sck_oe(sck_oe), .hold_empty(hold_empty), .idle(idle)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_hfull = 0, m_hold = 0, m_hnine = 0;
  int m_busy = 0, m_sh = 0, m_last = 7, m_bit = 0, m_phase = 0, m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n || !(port_en && master && tx_en && !rx_en)) begin
      m_hfull = 0; m_busy = 0; m_phase = 0; m_cnt = 0; m_bit = 0;
    end else begin
      int tk, endc, acc;
      tk   = m_busy && (m_cnt == int'(divisor));
      endc = tk && m_phase && (m_bit == m_last);
      acc  = in_valid && !m_hfull;
      if (m_hfull && (!m_busy || endc)) begin
        m_busy = 1; m_sh = m_hold; m_last = m_hnine ? 8 : 7;
        m_bit = 0; m_phase = 0; m_cnt = 0; m_hfull = 0;
      end else if (m_busy) begin
        if (tk) begin
          m_cnt = 0;
          if (!m_phase) m_phase = 1;
          else if (endc) begin m_busy = 0; m_phase = 0; end
          else begin m_phase = 0; m_bit++; end
        end else m_cnt++;
      end
      if (acc) begin
        m_hfull = 1; m_hold = {23'd0, bit9, in_data}; m_hnine = nine_bit;
      end
    end
  end

  // Per-cycle comparison and line observation
  bit got_bits[$];
  bit exp_bits[$];
  int lead_cnt = 0;
  logic prev_sck = 0;

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      automatic int e_dat = m_busy ? ((m_sh >> m_bit) & 1) : 0;
      automatic int e_sck = (m_busy && !m_phase) ? !clk_pol : clk_pol;
      automatic int e_oe  = port_en && master && tx_en && !rx_en;
      chk(dat_o == e_dat, "R3 dat_o", dat_o, e_dat);
      chk(sck_o == e_sck, "R5,R8 sck_o", sck_o, e_sck);
      chk(hold_empty == !m_hfull, "R1 hold_empty", hold_empty, !m_hfull);
      chk(idle == !m_busy, "R2 idle", idle, !m_busy);
      chk(dat_oe == e_oe && sck_oe == e_oe, "R9 oe", dat_oe, e_oe);
      if (prev_sck == clk_pol && sck_o != clk_pol) lead_cnt++;
      if (prev_sck != clk_pol && sck_o == clk_pol && !idle) got_bits.push_back(dat_o);
    end
    prev_sck = sck_o;
  end

  task automatic send(input logic [7:0] d, input logic nb, input logic b9);
    in_valid = 1; in_data = d; nine_bit = nb; bit9 = b9;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    for (int i = 0; i < 8; i++) exp_bits.push_back(d[i]);
    if (nb) exp_bits.push_back(b9);
  endtask

  task automatic drain_and_compare(input string tag);
    while (!(idle && hold_empty)) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(got_bits.size() == exp_bits.size(), {tag, " bit count"}, got_bits.size(), exp_bits.size());
    chk(lead_cnt == exp_bits.size(), "R4 leading edges", lead_cnt, exp_bits.size());
    for (int i = 0; i < exp_bits.size() && i < got_bits.size(); i++)
      chk(got_bits[i] == exp_bits[i], {tag, " bit value"}, got_bits[i], exp_bits[i]);
    got_bits.delete(); exp_bits.delete(); lead_cnt = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(idle == 1 && hold_empty == 1, "R11 reset flags", {idle, hold_empty}, 3);
    chk(dat_o == 0 && sck_o == clk_pol, "R11 reset lines", {dat_o, sck_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // Single 8-bit character, idle-low clock, LSB first
    divisor = 16'd2; clk_pol = 0;
    send(8'hA5, 0, 0);
    drain_and_compare("R3 single");

    // Back-to-back characters, idle-high clock, shortest half-bit
    clk_pol = 1; divisor = 16'd0;
    @(negedge clk);
    send(8'h3C, 0, 0);
    send(8'h81, 0, 0);
    chk(in_ready == 0 || idle == 0, "R2 waiting", in_ready, 0);
    send(8'hFF, 0, 0);
    drain_and_compare("R2 back-to-back");

    // 9-bit characters with both values of the ninth bit
    clk_pol = 0; divisor = 16'd3;
    @(negedge clk);
    send(8'h12, 1, 1);
    send(8'hED, 1, 0);
    drain_and_compare("R7 nine-bit");

    // Abort in the middle of a character with one waiting
    divisor = 16'd3;
    send(8'h55, 0, 0);
    send(8'hAA, 0, 0);
    repeat (5) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    chk(idle == 1 && hold_empty == 1, "R10 cleared", {idle, hold_empty}, 3);
    chk(sck_o == clk_pol, "R10 clock idle", sck_o, clk_pol);
    chk(in_ready == 0, "R10 not ready", in_ready, 0);
    got_bits.delete(); exp_bits.delete(); lead_cnt = 0;
    tx_en = 1;
    @(negedge clk);

    // Driver enables follow the mode inputs
    rx_en = 1; @(negedge clk);
    chk(dat_oe == 0 && sck_oe == 0, "R9 receive selected", {dat_oe, sck_oe}, 0);
    rx_en = 0; master = 0; @(negedge clk);
    chk(dat_oe == 0 && sck_oe == 0, "R9 not master", {dat_oe, sck_oe}, 0);
    master = 1; @(negedge clk);
    chk(dat_oe == 1 && sck_oe == 1, "R9 active", {dat_oe, sck_oe}, 3);

    // Transfer after abort, idle-high clock, longer half-bit (R6 data steady at trailing edge)
    clk_pol = 1; divisor = 16'd5;
    @(negedge clk);
    send(8'h6B, 0, 0);
    drain_and_compare("R6 after abort");

    finish_run();
  end
endmodule